// File: doc/BRIEF.md
# Interrupt Capture Bank

This block gathers 32 interrupt lines into pending bits and gives software a 32-bit word register interface to manage them. Each line carries its own configuration word: a 5-bit priority, a sensitivity bit that picks edge or level behaviour, and a route bit that sends the line to the fast path instead of the normal one. Pending bits are set from the pins, or from a software-set register that acts as if a pin had been raised. Software clears pending bits by writing the pending register. A mask register is stored here and driven out.

Choosing the winning line is done outside the block. An external arbiter looks at the pending, mask, route and priority outputs and returns two 5-bit winner codes, one for the normal path and one for the fast path. When software reads either code register it gets that code back. If the winning line is edge-type, the same read clears its pending bit, so the read acknowledges the interrupt.

Top module: `irq_capture_bank`

## Requirements
- R1: After reset the mask register reads 0xFFFFFFFF, and the pending bits, held inputs, sensitivity, route and priority values are all 0.
- R2: An edge-type line (sensitivity 0) sets its pending bit only when its registered input goes from 0 to 1. A line that stays high does not set again after software clears it.
- R3: A level-type line (sensitivity 1) sets its pending bit in every cycle that its pin is high. It clears the bit in the cycle its registered input falls.
- R4: When the input of an edge-type line falls, its pending bit stays set.
- R5: A write to offset 0x00 ANDs the write data into the pending bits. A level-type line whose held input is high keeps its pending bit.
- R6: The configuration word of line n is at offset 0x1C + 4*n. Bits [6:2] hold the priority, bit 1 the sensitivity and bit 0 the route. The word reads back in the same layout and drives prio_o and route_o.
- R7: Offset 0x04 is the mask register. It reads back as written and drives mask_o.
- R8: A read of offset 0x10 returns norm_code, and a read of offset 0x14 returns fast_code, both zero-extended. If the line named by the code is edge-type, the read clears its pending bit. A level-type line keeps its pending bit.
- R9: A write to offset 0x9C uses only the lowest set bit of the data. It sets that line's pending bit unless the line is edge-type and its held input is already high. The register reads as 0.
- R10: Offset 0x18 reads as 0. Writes are ignored at 0x18, at the code offsets 0x10 and 0x14, at unknown offsets and at any address with addr[1:0] not 0. Reads of unknown offsets return 0.
- R11: If a set from a pin or from software happens in the same cycle as a clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pins | input | 32 | Interrupt input lines |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; reads of the code registers have a side effect |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| norm_code | input | 5 | Winner on the normal path, from the external arbiter |
| fast_code | input | 5 | Winner on the fast path, from the external arbiter |
| pend_o | output | 32 | Pending bits |
| mask_o | output | 32 | Mask bits |
| route_o | output | 32 | Route bits, 1 sends the line to the fast path |
| prio_o | output | 160 | Priorities, line n at bits [5n+4:5n] |

## Verification
Capture is tried with four pin patterns: a single rise and fall on an edge line, a pin held high across a software clear, a level line that rises and then falls, and a pin rising in the same cycle as a pending clear. Together these separate edge behaviour from level behaviour and set priority from clear priority. Software-set is tried once on a line whose input is already high and once on a line whose input is low; this shows whether the held-input exemption is applied. Code reads are made once for an edge winner and once for a level winner, to show that only the edge winner is acknowledged by the read. Writes to aligned but read-only offsets, to unknown offsets and to misaligned offsets are each followed by a read-back, which shows that none of them changed any state.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

    localparam int unsigned LINES  = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned PRIO_W = 5;
    localparam int unsigned IDX_W  = $clog2(LINES);

    localparam logic [ADDR_W-1:0] OFF_PEND  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_NCODE = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FCODE = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h18;
    localparam logic [ADDR_W-1:0] CFG_BASE  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_SWSET = 8'h9C;
    localparam logic [ADDR_W-1:0] CFG_LAST  = CFG_BASE + ADDR_W'(4 * (LINES - 1));

    // bit layout of the per-line configuration word
    localparam int unsigned ROUTE_BIT = 0;
    localparam int unsigned SENS_BIT  = 1;
    localparam int unsigned PRIO_LSB  = 2;
    localparam int unsigned CFG_W     = PRIO_LSB + PRIO_W;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PEND,
        REG_MASK,
        REG_NCODE,
        REG_FCODE,
        REG_CTRL,
        REG_CFG,
        REG_SWSET
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } reg_hit_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } first_bit_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        h.sel = REG_NONE;
        h.idx = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= CFG_BASE && a <= CFG_LAST) begin
                h.sel = REG_CFG;
                h.idx = IDX_W'((a - CFG_BASE) >> 2);
            end else begin
                case (a)
                    OFF_PEND:  h.sel = REG_PEND;
                    OFF_MASK:  h.sel = REG_MASK;
                    OFF_NCODE: h.sel = REG_NCODE;
                    OFF_FCODE: h.sel = REG_FCODE;
                    OFF_CTRL:  h.sel = REG_CTRL;
                    OFF_SWSET: h.sel = REG_SWSET;
                    default:   h.sel = REG_NONE;
                endcase
            end
        end
        return h;
    endfunction

    // scan from the top so the lowest set bit is the last one written
    function automatic first_bit_t lowest_set(input logic [LINES-1:0] v);
        first_bit_t r;
        r.found = 1'b0;
        r.idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.found = 1'b1;
                r.idx   = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irqcap_cfg.sv
module irqcap_cfg
    import irqcap_pkg::*;
#(
    parameter int unsigned N_LINES = LINES,
    parameter int unsigned P_W     = PRIO_W,
    parameter int unsigned I_W     = IDX_W,
    parameter int unsigned W_W     = CFG_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [I_W-1:0]              cfg_idx,
    input  logic [W_W-1:0]              cfg_word,
    input  logic                        mask_we,
    input  logic [N_LINES-1:0]          mask_val,
    output logic [N_LINES-1:0]          mask,
    output logic [N_LINES-1:0]          sens,
    output logic [N_LINES-1:0]          route,
    output logic [N_LINES-1:0][P_W-1:0] prio
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '1;
            sens  <= '0;
            route <= '0;
            prio  <= '0;
        end else begin
            if (mask_we) begin
                mask <= mask_val;
            end
            for (int i = 0; i < int'(N_LINES); i++) begin
                if (cfg_we && cfg_idx == I_W'(i)) begin
                    prio[i]  <= cfg_word[PRIO_LSB +: P_W];
                    sens[i]  <= cfg_word[SENS_BIT];
                    route[i] <= cfg_word[ROUTE_BIT];
                end
            end
        end
    end

    // R6
    cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we)) |-> ($stable(prio) && $stable(sens) && $stable(route)));

    // R7
    mask_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mask_we)) |-> $stable(mask));

endmodule

// File: rtl/irqcap_pend.sv
module irqcap_pend
    import irqcap_pkg::*;
#(
    parameter int unsigned N_LINES = LINES,
    parameter int unsigned I_W     = IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pins,
    input  logic [N_LINES-1:0] sens,
    input  logic               clr_wr,
    input  logic [N_LINES-1:0] clr_val,
    input  logic               sw_valid,
    input  logic [I_W-1:0]     sw_idx,
    input  logic               vec_valid,
    input  logic [I_W-1:0]     vec_idx,
    output logic [N_LINES-1:0] pend
);

    logic [N_LINES-1:0] in_q;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] fall;
    logic [N_LINES-1:0] sw_vec;
    logic [N_LINES-1:0] set_v;
    logic [N_LINES-1:0] pend_nxt;

    assign rise   = pins & ~in_q;
    assign fall   = in_q & ~pins;
    assign sw_vec = sw_valid ? (N_LINES'(1) << sw_idx) : '0;

    // per-line set condition, chosen by sensitivity
    for (genvar g = 0; g < int'(N_LINES); g++) begin : g_set
        assign set_v[g] = sens[g] ? (pins[g] | sw_vec[g])
                                  : (rise[g] | (sw_vec[g] & ~in_q[g]));
    end

    // clears first, sets last, so a set in the same cycle wins
    always_comb begin
        pend_nxt = pend;
        if (clr_wr) begin
            pend_nxt = pend_nxt & (clr_val | (in_q & sens));
        end
        if (vec_valid && !sens[vec_idx]) begin
            pend_nxt[vec_idx] = 1'b0;
        end
        pend_nxt = pend_nxt & ~(fall & sens);
        pend_nxt = pend_nxt | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
            pend <= '0;
        end else begin
            in_q <= pins;
            pend <= pend_nxt;
        end
    end

    // R3
    level_track_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend & $past(pins & sens)) == $past(pins & sens)));

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!clr_wr && !vec_valid)) |-> (($past(pend & ~sens) & ~pend) == '0));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend & ~$past(pend) & ~$past(pins | sw_vec)) == '0));

    // R8
    vec_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(vec_valid && !sens[vec_idx] && !pins[vec_idx] && !sw_vec[vec_idx]))
        |-> !pend[$past(vec_idx)]);

endmodule

// File: rtl/irq_capture_bank.sv
module irq_capture_bank
    import irqcap_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LINES-1:0]        irq_pins,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [IDX_W-1:0]        norm_code,
    input  logic [IDX_W-1:0]        fast_code,
    output logic [LINES-1:0]        pend_o,
    output logic [LINES-1:0]        mask_o,
    output logic [LINES-1:0]        route_o,
    output logic [LINES*PRIO_W-1:0] prio_o
);

    reg_hit_t                      hit;
    first_bit_t                    sw_first;
    logic [LINES-1:0]              sens;
    logic [LINES-1:0][PRIO_W-1:0]  prio;
    logic                          vec_valid;
    logic [IDX_W-1:0]              vec_idx;

    assign hit      = decode_addr(bus_addr);
    assign sw_first = lowest_set(bus_wdata[LINES-1:0]);

    assign vec_valid = bus_rd && (hit.sel == REG_NCODE || hit.sel == REG_FCODE);
    assign vec_idx   = (hit.sel == REG_FCODE) ? fast_code : norm_code;

    irqcap_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (bus_wr && hit.sel == REG_CFG),
        .cfg_idx  (hit.idx),
        .cfg_word (bus_wdata[CFG_W-1:0]),
        .mask_we  (bus_wr && hit.sel == REG_MASK),
        .mask_val (bus_wdata[LINES-1:0]),
        .mask     (mask_o),
        .sens     (sens),
        .route    (route_o),
        .prio     (prio)
    );

    irqcap_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .pins      (irq_pins),
        .sens      (sens),
        .clr_wr    (bus_wr && hit.sel == REG_PEND),
        .clr_val   (bus_wdata[LINES-1:0]),
        .sw_valid  (bus_wr && hit.sel == REG_SWSET && sw_first.found),
        .sw_idx    (sw_first.idx),
        .vec_valid (vec_valid),
        .vec_idx   (vec_idx),
        .pend      (pend_o)
    );

    assign prio_o = prio;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (hit.sel)
                REG_PEND:  bus_rdata = DATA_W'(pend_o);
                REG_MASK:  bus_rdata = DATA_W'(mask_o);
                REG_NCODE: bus_rdata = DATA_W'(norm_code);
                REG_FCODE: bus_rdata = DATA_W'(fast_code);
                REG_CFG:   bus_rdata = DATA_W'({prio[hit.idx], sens[hit.idx], route_o[hit.idx]});
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R10
    quiet_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd || hit.sel == REG_NONE || hit.sel == REG_CTRL || hit.sel == REG_SWSET)
        |-> (bus_rdata == '0));

endmodule

// File: tb/tb_irq_capture_bank.sv
module tb_irq_capture_bank;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [31:0]  irq_pins = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [4:0]   norm_code = '0;
    logic [4:0]   fast_code = '0;
    logic [31:0]  pend_o, mask_o, route_o;
    logic [159:0] prio_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_capture_bank dut (
        .clk(clk), .rst(rst), .irq_pins(irq_pins),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .norm_code(norm_code), .fast_code(fast_code),
        .pend_o(pend_o), .mask_o(mask_o), .route_o(route_o), .prio_o(prio_o)
    );

    // op codes of the vector table
    localparam logic [1:0] OP_PINS = 2'd0;
    localparam logic [1:0] OP_WR   = 2'd1;
    localparam logic [1:0] OP_RD   = 2'd2;
    localparam logic [1:0] OP_CODE = 2'd3;
    localparam int NVEC = 41;

    // {req, op, addr, data, expected read}
    localparam logic [77:0] VEC [NVEC] = '{
        {4'd1,  OP_RD,   8'h04, 32'h0,        32'hFFFFFFFF}, // R1 mask reset
        {4'd1,  OP_RD,   8'h00, 32'h0,        32'h0},        // R1 pending reset
        {4'd2,  OP_PINS, 8'h00, 32'h1,        32'h0},        // R2 rise on line 0
        {4'd2,  OP_RD,   8'h00, 32'h0,        32'h1},        // R2
        {4'd4,  OP_PINS, 8'h00, 32'h0,        32'h0},        // R4 fall on line 0
        {4'd4,  OP_RD,   8'h00, 32'h0,        32'h1},        // R4 edge keeps
        {4'd5,  OP_WR,   8'h00, 32'hFFFFFFFE, 32'h0},        // R5 clear bit 0
        {4'd5,  OP_RD,   8'h00, 32'h0,        32'h0},        // R5
        {4'd6,  OP_WR,   8'h28, 32'h17,       32'h0},        // R6 line 3: prio 5, level, fast
        {4'd6,  OP_RD,   8'h28, 32'h0,        32'h17},       // R6 read back
        {4'd3,  OP_PINS, 8'h00, 32'h8,        32'h0},        // R3 level high
        {4'd3,  OP_RD,   8'h00, 32'h0,        32'h8},        // R3
        {4'd5,  OP_WR,   8'h00, 32'h0,        32'h0},        // R5 clear all
        {4'd5,  OP_RD,   8'h00, 32'h0,        32'h8},        // R5 level exempt
        {4'd3,  OP_PINS, 8'h00, 32'h0,        32'h0},        // R3 level fall
        {4'd3,  OP_RD,   8'h00, 32'h0,        32'h0},        // R3
        {4'd2,  OP_PINS, 8'h00, 32'h10,       32'h0},        // R2 rise on line 4
        {4'd2,  OP_RD,   8'h00, 32'h0,        32'h10},       // R2
        {4'd2,  OP_WR,   8'h00, 32'h0,        32'h0},        // R2 clear while held high
        {4'd2,  OP_RD,   8'h00, 32'h0,        32'h0},        // R2 no re-set
        {4'd9,  OP_WR,   8'h9C, 32'h30,       32'h0},        // R9 lowest = 4, input high
        {4'd9,  OP_RD,   8'h00, 32'h0,        32'h0},        // R9 no set
        {4'd9,  OP_WR,   8'h9C, 32'h60,       32'h0},        // R9 lowest = 5
        {4'd9,  OP_RD,   8'h00, 32'h0,        32'h20},       // R9 only bit 5
        {4'd9,  OP_RD,   8'h9C, 32'h0,        32'h0},        // R9 reads 0
        {4'd8,  OP_CODE, 8'h00, 32'h65,       32'h0},        // R8 norm 5, fast 3
        {4'd8,  OP_RD,   8'h10, 32'h0,        32'h5},        // R8 normal code
        {4'd8,  OP_RD,   8'h00, 32'h0,        32'h0},        // R8 edge acknowledged
        {4'd8,  OP_PINS, 8'h00, 32'h18,       32'h0},        // R8 line 3 level high
        {4'd8,  OP_RD,   8'h14, 32'h0,        32'h3},        // R8 fast code
        {4'd8,  OP_RD,   8'h00, 32'h0,        32'h8},        // R8 level not cleared
        {4'd7,  OP_WR,   8'h04, 32'hFFF0,     32'h0},        // R7 mask write
        {4'd7,  OP_RD,   8'h04, 32'h0,        32'hFFF0},     // R7
        {4'd10, OP_RD,   8'h18, 32'h0,        32'h0},        // R10 control reads 0
        {4'd10, OP_WR,   8'h18, 32'hFFFFFFFF, 32'h0},        // R10
        {4'd10, OP_WR,   8'h10, 32'h0,        32'h0},        // R10 code write
        {4'd10, OP_WR,   8'h05, 32'h0,        32'h0},        // R10 misaligned
        {4'd10, OP_RD,   8'h04, 32'h0,        32'hFFF0},     // R10 mask unchanged
        {4'd10, OP_RD,   8'h00, 32'h0,        32'h8},        // R10 pending unchanged
        {4'd10, OP_RD,   8'hA0, 32'h0,        32'h0},        // R10 unknown offset
        {4'd6,  OP_RD,   8'h1C, 32'h0,        32'h0}         // R6 line 0 untouched
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [31:0] exp);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b1;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            bus_rd = 1'b0;
            case (VEC[k][73:72])
                OP_PINS: irq_pins = VEC[k][63:32];
                OP_WR: begin
                    bus_wr = 1'b1;
                    bus_addr = VEC[k][71:64];
                    bus_wdata = VEC[k][63:32];
                end
                OP_RD: begin
                    bus_rd = 1'b1;
                    bus_addr = VEC[k][71:64];
                    #1;
                    checks++;
                    if (bus_rdata !== VEC[k][31:0]) begin
                        errors++;
                        $display("FAIL R%0d step %0d got %h exp %h",
                                 VEC[k][77:74], k, bus_rdata, VEC[k][31:0]);
                    end
                end
                default: begin
                    norm_code = VEC[k][36:32];
                    fast_code = VEC[k][41:37];
                end
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;

        // R6 configuration drives the outputs
        check("R6 route_o", route_o, 32'h8);
        check("R6 prio_o line3", {27'b0, prio_o[19:15]}, 32'h5);
        // R7 mask drives the output
        check("R7 mask_o", mask_o, 32'hFFF0);

        // R11 rise on line 0 in the same cycle as a full clear
        @(negedge clk);
        irq_pins = 32'h19;
        bus_wr = 1'b1;
        bus_addr = 8'h00;
        bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check("R11 set beats clear", pend_o, 32'h9);

        // R1 reset in mid-run
        irq_pins = 32'h0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 pend after reset", pend_o, 32'h0);
        check("R1 route after reset", route_o, 32'h0);
        check("R1 prio after reset", {27'b0, prio_o[19:15]}, 32'h0);
        rd(8'h04, "R1 mask after reset", 32'hFFFFFFFF);
        rd(8'h28, "R1 cfg after reset", 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule